// File: doc/BRIEF.md
# DMA Unit Transfer Engine

This block moves the data of one already-granted DMA channel, one unit at a time. A unit is a halfword or a word. For each unit the engine reads from the source address and then writes the returned data to the destination address, over a simple memory port that has one request in flight at a time. After each unit it steps both addresses according to their own control modes and lowers the remaining count.

Each unit has a cycle cost taken from per-region wait-state tables. The engine stays quiet for that many cycles before it starts the next unit. The first unit of a run uses the nonsequential tables and forces both addresses down to the unit width. Later units use the sequential tables.

Before each unit, the engine checks whether the CPU is held for some reason other than this transfer. If it is, the unit waits until that hold is gone. When the final unit's cost has elapsed, the engine pulses a completion strobe back to the scheduler.

Top module: `dma_xfer_engine`

## Requirements
- R1: While reset is asserted and right after it, the engine is idle: busy, done and mem_req are low, and remaining, cur_src and cur_dst read zero.
- R2: When start_word is 1, a unit is 4 bytes. When it is 0, a unit is 2 bytes. Every request carries that width on mem_word.
- R3: After each unit, each address moves by its own 2-bit mode. Mode 0 adds the unit width, mode 1 subtracts it, mode 2 holds the address, and mode 3 adds the width. For the destination only, mode 3 also restores the programmed start address once the run completes.
- R4: Before the first unit of a run, source and destination are aligned down to the unit width. For halfwords bit 0 is cleared. For words bits 1:0 are cleared.
- R5: A unit costs 2 cycles plus the source-region wait state plus the destination-region wait state. After a unit's write, the engine idles for exactly that cost, then spends one more cycle before the next read request.
- R6: ws_sel selects a wait-state table: 0 = nonsequential halfword, 1 = nonsequential word, 2 = sequential halfword, 3 = sequential word. The first unit of a run uses table 0 or 1 and later units use table 2 or 3, chosen by width. When ws_we is high, ws_value is written into entry ws_region of table ws_sel.
- R7: The region of an address is its top four bits, address[27:24]. The source and destination regions are looked up separately.
- R8: While cpu_blocked_other is sampled high, no new unit starts. A unit already in progress still finishes.
- R9: remaining is loaded with start_count, which must be at least 1, and drops by one after each unit's write. When the last unit's cost has elapsed, done pulses for one cycle with remaining at zero, and the engine returns to idle.
- R10: The engine holds each request's address, direction and data until mem_ack. The write is issued only after the read data has returned. It carries that data unchanged; for halfwords only the low 16 bits are kept and the upper bits are zero.
- R11: A start pulse while the engine is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run with the start_* values |
| start_src | input | 28 | Programmed source address |
| start_dst | input | 28 | Programmed destination address |
| start_count | input | 21 | Number of units, at least 1 |
| start_word | input | 1 | 1 = word units, 0 = halfword units |
| start_src_mode | input | 2 | Source address mode |
| start_dst_mode | input | 2 | Destination address mode |
| cpu_blocked_other | input | 1 | CPU held for a reason other than this transfer |
| ws_we | input | 1 | Wait-state table write strobe |
| ws_sel | input | 2 | Table select |
| ws_region | input | 4 | Region index within the table |
| ws_value | input | 4 | Wait-state value to store |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | Access width, 1 = word |
| mem_addr | output | 28 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion strobe |
| cur_src | output | 28 | Current source address |
| cur_dst | output | 28 | Current destination address |
| remaining | output | 21 | Units still to move |

## Verification
The bench runs several transfers and checks each against a behavioural model:
- Word runs with unaligned start addresses, which separate alignment from stepping.
- A halfword run with a decrementing source and a fixed destination, which shows that the two address paths are independent.
- A reloading destination, which has to come back to its programmed value.
- A single-unit run whose addresses sit in the highest and lowest regions, which tests region decoding at its limits.

Every table is loaded with different values, so a wrong table choice, a swapped region or a missing sequential switch all produce a different gap length between units. One run holds the CPU block longer than the unit cost, and another gets a stray start pulse partway through, which show the deferral and the ignore rule at the memory port.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GATE  = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_WAIT  = 3'd4
  } xfer_state_e;

  typedef enum logic [1:0] {
    AM_INC        = 2'd0,
    AM_DEC        = 2'd1,
    AM_FIX        = 2'd2,
    AM_INC_RELOAD = 2'd3
  } addr_mode_e;

  localparam int unsigned WS_TABLES = 4;

endpackage

// File: rtl/dma_ws_tables.sv
module dma_ws_tables
  import dma_xfer_pkg::*;
#(
  parameter int unsigned REGION_W = 4,
  parameter int unsigned WS_W     = 4,
  parameter int unsigned COST_W   = WS_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_sel,
  input  logic [REGION_W-1:0] cfg_region,
  input  logic [WS_W-1:0]     cfg_value,
  input  logic                seq,
  input  logic                word,
  input  logic [REGION_W-1:0] src_region,
  input  logic [REGION_W-1:0] dst_region,
  output logic [COST_W-1:0]   cost
);

  localparam int unsigned NREG = 1 << REGION_W;

  logic [WS_W-1:0] tbl_q  [WS_TABLES][NREG];
  logic            wr_en  [WS_TABLES][NREG];

  for (genvar t = 0; t < WS_TABLES; t++) begin : g_tbl
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_comb begin
        wr_en[t][r] = cfg_we && (cfg_sel == 2'(t)) && (cfg_region == REGION_W'(r));
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tbl_q[t][r] <= '0;
        end else if (wr_en[t][r]) begin
          tbl_q[t][r] <= cfg_value;
        end
      end
    end
  end

  logic [1:0]      rd_sel;
  logic [WS_W-1:0] ws_src;
  logic [WS_W-1:0] ws_dst;

  always_comb begin
    rd_sel = {seq, word};
    ws_src = tbl_q[rd_sel][src_region];
    ws_dst = tbl_q[rd_sel][dst_region];
    cost   = COST_W'(2) + {{(COST_W-WS_W){1'b0}}, ws_src}
                        + {{(COST_W-WS_W){1'b0}}, ws_dst};
  end

  // R5
  cost_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cost >= COST_W'(2));

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  addr_mode_e        mode,
  input  logic              word,
  input  logic              align,
  input  logic              advance,
  input  logic              reload,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] origin_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] align_mask;

  always_comb begin
    step       = word ? ADDR_W'(4) : ADDR_W'(2);
    align_mask = word ? ~ADDR_W'(3) : ~ADDR_W'(1);
    addr_d     = addr_q;
    if (load) begin
      addr_d = load_addr;
    end else if (reload) begin
      addr_d = (mode == AM_INC_RELOAD) ? origin_q : addr_q;
    end else if (align) begin
      addr_d = addr_q & align_mask;
    end else if (advance) begin
      unique case (mode)
        AM_INC, AM_INC_RELOAD: addr_d = addr_q + step;
        AM_DEC:                addr_d = addr_q - step;
        default:               addr_d = addr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      origin_q <= '0;
    end else if (load) begin
      origin_q <= load_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load || reload || align || advance) begin
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;

  // R3
  fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && !reload && !align && mode == AM_FIX) |=> $stable(addr_q));

  // R4
  half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (align && !load && !reload) |=> (addr_q[0] == 1'b0));

  // R4
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (align && word && !load && !reload) |=> (addr_q[1:0] == 2'b00));

endmodule

// File: rtl/dma_cost_timer.sv
module dma_cost_timer #(
  parameter int unsigned COST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [COST_W-1:0] load_val,
  input  logic              run,
  output logic              last
);

  logic [COST_W-1:0] cnt_q;
  logic [COST_W-1:0] cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = load || (run && cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - COST_W'(1);
    last   = run && (cnt_q == COST_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R5
  wait_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q != '0));

  // R5
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W   = 28,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 21,
  parameter int unsigned REGION_W = 4,
  parameter int unsigned WS_W     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   start_src,
  input  logic [ADDR_W-1:0]   start_dst,
  input  logic [CNT_W-1:0]    start_count,
  input  logic                start_word,
  input  logic [1:0]          start_src_mode,
  input  logic [1:0]          start_dst_mode,
  input  logic                cpu_blocked_other,
  input  logic                ws_we,
  input  logic [1:0]          ws_sel,
  input  logic [REGION_W-1:0] ws_region,
  input  logic [WS_W-1:0]     ws_value,
  output logic                mem_req,
  output logic                mem_we,
  output logic                mem_word,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic                mem_ack,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                busy,
  output logic                done,
  output logic [ADDR_W-1:0]   cur_src,
  output logic [ADDR_W-1:0]   cur_dst,
  output logic [CNT_W-1:0]    remaining
);

  localparam int unsigned COST_W = WS_W + 2;
  localparam int unsigned HALF_W = DATA_W / 2;

  xfer_state_e       state_q, state_d;
  logic              word_q;
  addr_mode_e        src_mode_q, dst_mode_q;
  logic              first_q;
  logic [CNT_W-1:0]  remaining_q;
  logic [DATA_W-1:0] data_q;
  logic [COST_W-1:0] cost_q;
  logic [COST_W-1:0] ws_cost;

  logic load_go, align_go, step_go, done_go, cap_cost, cap_data;
  logic tmr_last;
  logic [ADDR_W-1:0] src_addr, dst_addr;

  always_comb begin
    state_d  = state_q;
    load_go  = 1'b0;
    align_go = 1'b0;
    step_go  = 1'b0;
    done_go  = 1'b0;
    cap_cost = 1'b0;
    cap_data = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_GATE;
          load_go = 1'b1;
        end
      end
      ST_GATE: begin
        if (!cpu_blocked_other) begin
          state_d  = ST_READ;
          cap_cost = 1'b1;
          align_go = first_q;
        end
      end
      ST_READ: begin
        if (mem_ack) begin
          state_d  = ST_WRITE;
          cap_data = 1'b1;
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          state_d = ST_WAIT;
          step_go = 1'b1;
        end
      end
      ST_WAIT: begin
        if (tmr_last) begin
          if (remaining_q == '0) begin
            state_d = ST_IDLE;
            done_go = 1'b1;
          end else begin
            state_d = ST_GATE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q     <= 1'b0;
      src_mode_q <= AM_INC;
      dst_mode_q <= AM_INC;
    end else if (load_go) begin
      word_q     <= start_word;
      src_mode_q <= addr_mode_e'(start_src_mode);
      dst_mode_q <= addr_mode_e'(start_dst_mode);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining_q <= '0;
      first_q     <= 1'b0;
    end else if (load_go) begin
      remaining_q <= start_count;
      first_q     <= 1'b1;
    end else if (step_go) begin
      remaining_q <= remaining_q - CNT_W'(1);
      first_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cost_q <= '0;
    end else if (cap_cost) begin
      cost_q <= ws_cost;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cap_data) begin
      data_q <= mem_rdata;
    end
  end

  dma_ws_tables #(
    .REGION_W (REGION_W),
    .WS_W     (WS_W),
    .COST_W   (COST_W)
  ) u_ws_tables (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (ws_we),
    .cfg_sel    (ws_sel),
    .cfg_region (ws_region),
    .cfg_value  (ws_value),
    .seq        (!first_q),
    .word       (word_q),
    .src_region (src_addr[ADDR_W-1 -: REGION_W]),
    .dst_region (dst_addr[ADDR_W-1 -: REGION_W]),
    .cost       (ws_cost)
  );

  dma_addr_step #(.ADDR_W(ADDR_W)) u_src_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_go),
    .load_addr (start_src),
    .mode      (src_mode_q),
    .word      (word_q),
    .align     (align_go),
    .advance   (step_go),
    .reload    (1'b0),
    .addr      (src_addr)
  );

  dma_addr_step #(.ADDR_W(ADDR_W)) u_dst_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_go),
    .load_addr (start_dst),
    .mode      (dst_mode_q),
    .word      (word_q),
    .align     (align_go),
    .advance   (step_go),
    .reload    (done_go),
    .addr      (dst_addr)
  );

  dma_cost_timer #(.COST_W(COST_W)) u_cost_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (step_go),
    .load_val (cost_q),
    .run      (state_q == ST_WAIT),
    .last     (tmr_last)
  );

  always_comb begin
    mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
    mem_we    = (state_q == ST_WRITE);
    mem_word  = word_q;
    mem_addr  = mem_we ? dst_addr : src_addr;
    mem_wdata = word_q ? data_q : {{(DATA_W-HALF_W){1'b0}}, data_q[HALF_W-1:0]};
    busy      = (state_q != ST_IDLE);
    done      = done_go;
    cur_src   = src_addr;
    cur_dst   = dst_addr;
    remaining = remaining_q;
  end

  // R10
  rd_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && !mem_ack) |=> !(mem_req && mem_we));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R8
  defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GATE && cpu_blocked_other) |=> (state_q == ST_GATE));

  // R9
  done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (remaining == '0 && !mem_req));

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !step_go) |=> $stable(remaining));

endmodule

// File: tb/dma_xfer_engine_bench.sv
module dma_xfer_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [27:0] start_src = '0;
  logic [27:0] start_dst = '0;
  logic [20:0] start_count = '0;
  logic        start_word = 1'b0;
  logic [1:0]  start_src_mode = '0;
  logic [1:0]  start_dst_mode = '0;
  logic        cpu_blocked_other = 1'b0;
  logic        ws_we = 1'b0;
  logic [1:0]  ws_sel = '0;
  logic [3:0]  ws_region = '0;
  logic [3:0]  ws_value = '0;
  logic        mem_req, mem_we, mem_word;
  logic [27:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        busy, done;
  logic [27:0] cur_src, cur_dst;
  logic [20:0] remaining;

  always #5 clk = ~clk;

  dma_xfer_engine u_dma_xfer_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .start_src(start_src),
    .start_dst(start_dst), .start_count(start_count), .start_word(start_word),
    .start_src_mode(start_src_mode), .start_dst_mode(start_dst_mode),
    .cpu_blocked_other(cpu_blocked_other), .ws_we(ws_we), .ws_sel(ws_sel),
    .ws_region(ws_region), .ws_value(ws_value), .mem_req(mem_req),
    .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .cur_src(cur_src), .cur_dst(cur_dst),
    .remaining(remaining)
  );

  int chk_cnt = 0;
  int err_cnt = 0;
  int cyc = 0;

  int tbl [4][16];
  int q_rd[$], q_wr[$], q_cost[$], q_rem[$];
  bit run_word;
  bit running = 0;
  bit first_unit = 0;
  bit post_pending = 0;
  bit run_done = 0;
  int exp_fsrc, exp_fdst;
  int quiet = 0;
  int exp_gap = 0;
  int last_cost = 0;
  int unit_idx = 0;
  int block_unit = -1;
  int block_len = 0;
  int blk_left = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    chk_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int mem_fn(input int a);
    return (a * 32'h9E37) ^ 32'hC3A5_5A3C;
  endfunction

  function automatic int step_addr(input int a, input int mode, input int w);
    case (mode)
      0, 3:    return (a + w) & 32'h0FFF_FFFF;
      1:       return (a - w) & 32'h0FFF_FFFF;
      default: return a;
    endcase
  endfunction

  // memory responder, CPU-block driver and reference comparison
  always @(negedge clk) begin
    bit ack_prev;
    if (rst_n) begin
      if (blk_left > 0) begin
        blk_left--;
        if (blk_left == 0) cpu_blocked_other = 1'b0;
      end
      if (post_pending) begin
        post_pending = 0;
        check(cur_src == exp_fsrc[27:0], "R3", "final source", cur_src, exp_fsrc);
        check(cur_dst == exp_fdst[27:0], "R3", "final destination (reload)", cur_dst, exp_fdst);
        check(!busy, "R9", "idle after done", busy, 0);
        running = 0;
        run_done = 1;
      end
      ack_prev = mem_ack;
      mem_ack = 1'b0;
      if (mem_req && !ack_prev) begin
        mem_ack = 1'b1;
        mem_rdata = mem_fn({4'b0, mem_addr});
        if (q_rd.size() == 0) begin
          check(0, "R11", "request with no unit expected", mem_addr, 0);
        end else if (!mem_we) begin
          check(mem_addr == q_rd[0][27:0], first_unit ? "R4" : "R3",
                "read address", mem_addr, q_rd[0]);
          check(mem_word == run_word, "R2", "read width", mem_word, run_word);
          if (!first_unit)
            check(quiet == exp_gap, "R5 R6 R7 R8", "idle cycles before unit",
                  quiet, exp_gap);
        end else begin
          int expd;
          expd = run_word ? mem_fn(q_rd[0]) : (mem_fn(q_rd[0]) & 32'h0000_FFFF);
          check(mem_addr == q_wr[0][27:0], first_unit ? "R4" : "R3",
                "write address", mem_addr, q_wr[0]);
          check(mem_wdata == expd, "R10", "write data", mem_wdata, expd);
          check(mem_word == run_word, "R2", "write width", mem_word, run_word);
          check(remaining == q_rem[0][20:0], "R9", "remaining before step",
                remaining, q_rem[0]);
          last_cost = q_cost[0];
          exp_gap = last_cost + 1;
          if (unit_idx == block_unit) begin
            cpu_blocked_other = 1'b1;
            blk_left = block_len;
            if (block_len > exp_gap) exp_gap = block_len;
          end
          void'(q_rd.pop_front());
          void'(q_wr.pop_front());
          void'(q_cost.pop_front());
          void'(q_rem.pop_front());
          quiet = 0;
          first_unit = 0;
          unit_idx++;
        end
      end else if (busy && !mem_req) begin
        quiet++;
      end
      if (done) begin
        if (!running || q_rd.size() != 0) begin
          check(0, "R9", "unexpected done", q_rd.size(), 0);
        end else begin
          check(quiet == last_cost, "R5 R9", "cost before done", quiet, last_cost);
          check(remaining == 0, "R9", "remaining at done", remaining, 0);
          post_pending = 1;
        end
      end
    end
  end

  task automatic load_tables();
    for (int t = 0; t < 4; t++) begin
      for (int r = 0; r < 16; r++) begin
        case (t)
          0: tbl[t][r] = (r % 5) + 1;
          1: tbl[t][r] = (r * 3) % 7;
          2: tbl[t][r] = r % 3;
          default: tbl[t][r] = (r + 2) % 4;
        endcase
        @(negedge clk);
        ws_we = 1'b1;
        ws_sel = t[1:0];
        ws_region = r[3:0];
        ws_value = tbl[t][r][3:0];
      end
    end
    @(negedge clk);
    ws_we = 1'b0;
  endtask

  task automatic do_run(input int src, input int dst, input int cnt, input bit word,
                        input int sm, input int dm, input int blk_u, input int blk_n,
                        input bit inject);
    int w, s, d, sel, c;
    w = word ? 4 : 2;
    s = src & ~(w - 1);
    d = dst & ~(w - 1);
    for (int k = 0; k < cnt; k++) begin
      sel = (k > 0 ? 2 : 0) + (word ? 1 : 0);
      c = 2 + tbl[sel][(s >> 24) & 15] + tbl[sel][(d >> 24) & 15];
      q_rd.push_back(s);
      q_wr.push_back(d);
      q_cost.push_back(c);
      q_rem.push_back(cnt - k);
      s = step_addr(s, sm, w);
      d = step_addr(d, dm, w);
    end
    exp_fsrc = s;
    exp_fdst = (dm == 3) ? dst : d;
    run_word = word;
    block_unit = blk_u;
    block_len = blk_n;
    unit_idx = 0;
    first_unit = 1;
    run_done = 0;
    running = 1;
    @(negedge clk);
    start = 1'b1;
    start_src = src[27:0];
    start_dst = dst[27:0];
    start_count = cnt[20:0];
    start_word = word;
    start_src_mode = sm[1:0];
    start_dst_mode = dm[1:0];
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      repeat (6) @(negedge clk);
      // R11: stray start while busy with different parameters
      start = 1'b1;
      start_src = 28'h0000_100;
      start_dst = 28'h0000_200;
      start_count = 21'd9;
      start_word = ~word;
      start_src_mode = 2'd1;
      start_dst_mode = 2'd2;
      @(negedge clk);
      start = 1'b0;
    end
    while (!run_done) @(negedge clk);
    repeat (30) @(negedge clk);
    check(!busy && !mem_req, "R11", "no activity after run", {busy, mem_req}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1
    check(!busy, "R1", "busy in reset", busy, 0);
    check(!mem_req, "R1", "mem_req in reset", mem_req, 0);
    check(!done, "R1", "done in reset", done, 0);
    check(remaining == 0, "R1", "remaining in reset", remaining, 0);
    check(cur_src == 0 && cur_dst == 0, "R1", "addresses in reset", {cur_src, cur_dst}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !mem_req, "R1", "idle after reset", {busy, mem_req}, 0);
    // R6: table programming
    load_tables();
    // R2 R4: word, increment both, unaligned, stray start (R11)
    do_run(32'h0100_0003, 32'h0200_0006, 4, 1'b1, 0, 0, -1, 0, 1'b1);
    // R3: halfword, decrementing source, fixed destination
    do_run(32'h0300_0011, 32'h0500_0020, 3, 1'b0, 1, 2, -1, 0, 1'b0);
    // R3: word, fixed source, reloading destination
    do_run(32'h0700_0040, 32'h0800_0102, 3, 1'b1, 2, 3, -1, 0, 1'b0);
    // R8: halfword with CPU held by another cause after unit 1
    do_run(32'h0400_0001, 32'h0600_0010, 4, 1'b0, 0, 0, 1, 20, 1'b0);
    // R7: single unit at the highest and lowest regions
    do_run(32'h0F00_000A, 32'h0000_0005, 1, 1'b1, 0, 1, -1, 0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, err_cnt);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      err_cnt++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, err_cnt);
      $finish;
    end
  end

endmodule